// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block is the digital controller that sits in front of a successive-approximation analog converter. Software programs a small register set over a simple read/write bus. The registers choose the start source, a contiguous channel window, a once-or-repeat scan mode and the length of the sampling phase. Once started, the controller walks through the channel window in ascending order. For each channel it raises a sample strobe for the programmed number of clock periods, then holds a convert request until the analog side answers with a one-cycle done pulse and a 10-bit code.

Each code is stored in the result slot of its channel, and a per-channel ready flag is set. Reading a result slot clears that channel's flag. The conversion clock is the block clock. Register map (word addresses): 0 = trigger/channel select, 1 = control/status, 2 = ready flags (bit n = channel n), 8 + n = result of channel n in bits [9:0]. Read data appears on the bus one cycle after the read strobe.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the select register (address 0) reads 0, which means single-scan mode, the software source and channel window 0..0. The control register (address 1) reads 0x0300, which is sampling code 11 with the busy bit clear. The flag register (address 2) reads 0.
- R2: Address 0 holds the source code in bits [4:3], the scan mode in bit 5, the start channel in bits [10:8] and the end channel in bits [13:11]. With source code 00, writing address 1 with bit 1 set starts a scan while idle. Bit 1 of address 1 reads 1 for as long as a scan runs.
- R3: With source code 01, a one-cycle pulse on `tmr_match` starts a scan.
- R4: With source code 11, a low level on `ext_trig_n` starts a scan after passing a two-flop synchronizer. The level stays effective while it is held low.
- R5: Source code 10 never starts a scan. A source that is not selected has no effect.
- R6: With bit 5 = 0, the channels from start to end are each converted once, in ascending order. The block then returns to idle.
- R7: When the end channel is below the start channel, only the start channel is converted.
- R8: With bit 5 = 1, the window is scanned repeatedly. Writing address 1 with bit 1 clear during a scan lets the channel in progress complete and then returns to idle.
- R9: Bits [9:8] of address 1 set the time `afe_sample` stays high: 3, 5, 7 or 9 clock cycles for codes 00, 01, 10 and 11.
- R10: Each done pulse stores `afe_result` at address 8 + channel and sets bit channel of address 2. Reading that result address clears the flag.
- R11: Start events of any source that arrive while a scan runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| tmr_match | input | 1 | Timer compare-match pulse |
| ext_trig_n | input | 1 | Asynchronous active-low external start |
| afe_sample | output | 1 | Sample phase strobe to the analog front end |
| afe_conv | output | 1 | Convert request, held until `afe_done` |
| afe_chan | output | 3 | Channel currently selected |
| afe_done | input | 1 | One-cycle conversion-complete pulse |
| afe_result | input | 10 | Conversion code, valid with `afe_done` |

## Verification
The assertions rely on the analog side raising `afe_done` only while `afe_conv` is high, and for exactly one cycle per request. The bench model of the front end waits a fixed number of cycles after seeing the request, pulses done once, and then stays silent until the next request. The checks also assume that software sets the mode and the channel window only while idle. The stimulus writes the select register only after the busy bit has dropped, and it issues its stop write only during a sample phase, so a stop never lands on the same edge as a done pulse.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_CONV   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_SOFT  = 2'b00,
    SRC_TIMER = 2'b01,
    SRC_NONE  = 2'b10,
    SRC_PIN   = 2'b11
  } start_src_e;

  // field positions in the select register
  localparam int SEL_SRC_LSB = 3;
  localparam int SEL_MODE_BIT = 5;
  localparam int SEL_LO_LSB = 8;
  localparam int SEL_HI_LSB = 11;
  // field positions in the control register
  localparam int CTL_RUN_BIT = 1;
  localparam int CTL_SAMP_LSB = 8;

endpackage

// File: rtl/adc_start_mux.sv
module adc_start_mux
  import adc_scan_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       soft_go,
  input  logic       tmr_match,
  input  logic       ext_trig_n,
  output logic       start_req
);

  logic [SYNC_N-1:0] pin_sync_q;
  logic [SYNC_N-1:0] pin_sync_d;
  logic              pin_low;

  always_comb begin
    pin_sync_d = {pin_sync_q[SYNC_N-2:0], ext_trig_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync_q <= '1;
    end else begin
      pin_sync_q <= pin_sync_d;
    end
  end

  assign pin_low = ~pin_sync_q[SYNC_N-1];

  always_comb begin
    case (start_src_e'(src_sel))
      SRC_SOFT:  start_req = soft_go;
      SRC_TIMER: start_req = tmr_match;
      SRC_PIN:   start_req = pin_low;
      default:   start_req = 1'b0;
    endcase
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            mode_cont,
  input  logic [CH_W-1:0] ch_lo,
  input  logic [CH_W-1:0] ch_hi,
  input  logic [1:0]      samp_code,
  input  logic            stop_req,
  input  logic            afe_done,
  output logic            busy,
  output logic            afe_sample,
  output logic            afe_conv,
  output logic [CH_W-1:0] afe_chan,
  output logic            res_we
);

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic [CH_W-1:0] lo_q, lo_d;
  logic [CH_W-1:0] hi_q, hi_d;
  logic            cont_q, cont_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] samp_last;
  logic            load_en;

  // sampling length minus one: 2, 4, 6 or 8
  assign samp_last = CNT_W'(2) + CNT_W'({samp_code, 1'b0});

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    cont_d  = cont_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_req) begin
          load_en = 1'b1;
          lo_d    = ch_lo;
          hi_d    = (ch_hi < ch_lo) ? ch_lo : ch_hi;
          cont_d  = mode_cont;
          chan_d  = ch_lo;
          cnt_d   = '0;
          state_d = SEQ_SAMPLE;
        end
      end
      SEQ_SAMPLE: begin
        if (cnt_q == samp_last) begin
          cnt_d   = '0;
          state_d = SEQ_CONV;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      SEQ_CONV: begin
        if (afe_done) begin
          cnt_d = '0;
          if (stop_req) begin
            state_d = SEQ_IDLE;
          end else if (chan_q == hi_q) begin
            if (cont_q) begin
              chan_d  = lo_q;
              state_d = SEQ_SAMPLE;
            end else begin
              state_d = SEQ_IDLE;
            end
          end else begin
            chan_d  = chan_q + CH_W'(1);
            state_d = SEQ_SAMPLE;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      chan_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      cont_q <= 1'b0;
    end else if (load_en) begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      cont_q <= cont_d;
    end
  end

  assign busy       = (state_q != SEQ_IDLE);
  assign afe_sample = (state_q == SEQ_SAMPLE);
  assign afe_conv   = (state_q == SEQ_CONV);
  assign afe_chan   = chan_q;
  assign res_we     = afe_conv && afe_done;

  // R9: the sample phase always hands over to a convert request
  a_r9_sample_to_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(afe_sample) |-> afe_conv);

  // R6: the active channel stays inside the latched window
  a_r6_chan_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (afe_chan >= lo_q && afe_chan <= hi_q));

  // R10: a convert request is held until the front end answers
  a_r10_conv_held: assert property (@(posedge clk) disable iff (!rst_n)
    (afe_conv && !afe_done) |=> afe_conv);

  a_r9_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({afe_sample, afe_conv}));

  // R9: the counter never runs past the longest window
  a_r9_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    afe_sample |-> (cnt_q <= CNT_W'(8)));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [CH_W-1:0]                wr_ch,
  input  logic [RES_W-1:0]               wr_data,
  input  logic                           clr_en,
  input  logic [CH_W-1:0]                clr_ch,
  output logic [(1<<CH_W)-1:0][RES_W-1:0] res_o,
  output logic [(1<<CH_W)-1:0]           flag_o
);

  localparam int NUM_CH = 1 << CH_W;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic wr_hit, clr_hit, flag_d;

    assign wr_hit  = wr_en && (wr_ch == CH_W'(g));
    assign clr_hit = clr_en && (clr_ch == CH_W'(g));

    always_comb begin
      flag_d = flag_o[g];
      if (wr_hit) flag_d = 1'b1;
      else if (clr_hit) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_o[g] <= 1'b0;
      end else begin
        flag_o[g] <= flag_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_o[g] <= '0;
      end else if (wr_hit) begin
        res_o[g] <= wr_data;
      end
    end
  end

  // R10: a stored result always leaves its ready flag set
  a_r10_flag_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> flag_o[$past(wr_ch)]);

  // R10: reading a slot clears its flag unless a store hits it at once
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(wr_en && wr_ch == clr_ch)) |=> !flag_o[$past(clr_ch)]);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int RES_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_match,
  input  logic              ext_trig_n,
  output logic              afe_sample,
  output logic              afe_conv,
  output logic [CH_W-1:0]   afe_chan,
  input  logic              afe_done,
  input  logic [RES_W-1:0]  afe_result
);

  localparam int NUM_CH = 1 << CH_W;
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(2);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // register fields
  logic [1:0]      src_q, src_d;
  logic            mode_q, mode_d;
  logic [CH_W-1:0] lo_q, lo_d;
  logic [CH_W-1:0] hi_q, hi_d;
  logic [1:0]      samp_q, samp_d;
  logic            stop_q, stop_d;
  logic            sel_we, ctl_we;
  logic            soft_go, start_req, busy, res_we;
  logic            is_res_addr;
  logic [DATA_W-1:0] rdata_d;
  logic [NUM_CH-1:0][RES_W-1:0] res_all;
  logic [NUM_CH-1:0]            flags;

  assign sel_we      = bus_wr && (bus_addr == A_SEL);
  assign ctl_we      = bus_wr && (bus_addr == A_CTL);
  assign is_res_addr = bus_addr[ADDR_W-1];
  assign soft_go     = ctl_we && bus_wdata[CTL_RUN_BIT];

  always_comb begin
    src_d  = bus_wdata[SEL_SRC_LSB +: 2];
    mode_d = bus_wdata[SEL_MODE_BIT];
    lo_d   = bus_wdata[SEL_LO_LSB +: CH_W];
    hi_d   = bus_wdata[SEL_HI_LSB +: CH_W];
    samp_d = bus_wdata[CTL_SAMP_LSB +: 2];
    stop_d = stop_q;
    if (!busy) stop_d = 1'b0;
    if (ctl_we && !bus_wdata[CTL_RUN_BIT] && busy) stop_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_q  <= 2'b00;
      mode_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (sel_we) begin
      src_q  <= src_d;
      mode_q <= mode_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      samp_q <= 2'b11;
    end else if (ctl_we) begin
      samp_q <= samp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) stop_q <= 1'b0;
    else             stop_q <= stop_d;
  end

  adc_start_mux #(.SYNC_N(2)) u_start (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .src_sel    (src_q),
    .soft_go    (soft_go),
    .tmr_match  (tmr_match),
    .ext_trig_n (ext_trig_n),
    .start_req  (start_req)
  );

  adc_scan_seq #(.CH_W(CH_W), .CNT_W(4)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_req  (start_req),
    .mode_cont  (mode_q),
    .ch_lo      (lo_q),
    .ch_hi      (hi_q),
    .samp_code  (samp_q),
    .stop_req   (stop_q),
    .afe_done   (afe_done),
    .busy       (busy),
    .afe_sample (afe_sample),
    .afe_conv   (afe_conv),
    .afe_chan   (afe_chan),
    .res_we     (res_we)
  );

  adc_result_bank #(.CH_W(CH_W), .RES_W(RES_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (res_we),
    .wr_ch   (afe_chan),
    .wr_data (afe_result),
    .clr_en  (bus_rd && is_res_addr),
    .clr_ch  (bus_addr[CH_W-1:0]),
    .res_o   (res_all),
    .flag_o  (flags)
  );

  always_comb begin
    rdata_d = '0;
    if (is_res_addr) begin
      rdata_d[RES_W-1:0] = res_all[bus_addr[CH_W-1:0]];
    end else if (bus_addr == A_SEL) begin
      rdata_d[SEL_SRC_LSB +: 2]    = src_q;
      rdata_d[SEL_MODE_BIT]        = mode_q;
      rdata_d[SEL_LO_LSB +: CH_W]  = lo_q;
      rdata_d[SEL_HI_LSB +: CH_W]  = hi_q;
    end else if (bus_addr == A_CTL) begin
      rdata_d[CTL_SAMP_LSB +: 2] = samp_q;
      rdata_d[CTL_RUN_BIT]       = busy;
    end else if (bus_addr == A_FLAG) begin
      rdata_d[NUM_CH-1:0] = flags;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rdata_d;
    end
  end

  // R5: an idle block with the reserved source selected stays idle
  a_r5_reserved_no_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && src_q == 2'b10) |=> !busy);

  // R6: every scan opens on the programmed start channel
  a_r6_scan_opens_at_lo: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> (afe_chan == $past(lo_q)));

  // R9: a new scan always opens with a sample phase
  a_r9_start_samples: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> afe_sample);

endmodule

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tmr_match, ext_trig_n;
  logic        afe_sample, afe_conv, afe_done;
  logic [2:0]  afe_chan;
  logic [9:0]  afe_result;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_match(tmr_match), .ext_trig_n(ext_trig_n),
    .afe_sample(afe_sample), .afe_conv(afe_conv), .afe_chan(afe_chan),
    .afe_done(afe_done), .afe_result(afe_result)
  );

  // analog front-end model and activity log
  int         conv_cnt = 0;
  logic [2:0] ch_log [0:63];
  logic [9:0] exp_res [0:7];
  logic [2:0] fe_wait;
  logic [6:0] seq_no;
  int         samp_run, last_samp;

  always @(posedge clk) begin
    if (!rst_n) begin
      afe_done <= 1'b0; afe_result <= '0; fe_wait <= '0; seq_no <= '0;
      samp_run <= 0; last_samp <= 0;
    end else begin
      afe_done <= 1'b0;
      if (afe_conv && !afe_done) begin
        if (fe_wait == 3'd3) begin
          afe_done   <= 1'b1;
          afe_result <= {seq_no, afe_chan};
          seq_no     <= seq_no + 7'd1;
          fe_wait    <= '0;
        end else begin
          fe_wait <= fe_wait + 3'd1;
        end
      end
      if (afe_done) begin
        ch_log[conv_cnt % 64] <= afe_chan;
        exp_res[afe_chan]     <= afe_result;
        conv_cnt              <= conv_cnt + 1;
      end
      if (afe_sample) samp_run <= samp_run + 1;
      else if (samp_run != 0) begin
        last_samp <= samp_run;
        samp_run  <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] sel_word(input logic [2:0] hi, input logic [2:0] lo,
                                           input logic ms, input logic [1:0] src);
    return {2'b00, hi, lo, 2'b00, ms, src, 3'b000};
  endfunction

  function automatic logic [15:0] ctl_word(input logic [1:0] st, input logic go);
    return {6'b0, st, 6'b0, go, 1'b0};
  endfunction

  task automatic wait_idle();
    logic [15:0] r;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!afe_sample && !afe_conv) begin
        bus_read(4'd1, r);
        if (!r[1]) return;
      end
    end
    chk(1'b0, "idle-timeout", 1, 0);
  endtask

  task automatic t_reset();
    logic [15:0] r;
    bus_read(4'd0, r); chk(r == 16'h0000, "R1 select reg", r, 16'h0000);
    bus_read(4'd1, r); chk(r == 16'h0300, "R1 control reg", r, 16'h0300);
    bus_read(4'd2, r); chk(r == 16'h0000, "R1 flags", r, 16'h0000);
  endtask

  task automatic t_soft_scan();
    logic [15:0] r;
    int base;
    bus_write(4'd0, sel_word(3'd4, 3'd1, 1'b0, 2'b00));
    bus_read(4'd0, r);
    chk(r == sel_word(3'd4, 3'd1, 1'b0, 2'b00), "R2 select readback", r, sel_word(3'd4, 3'd1, 1'b0, 2'b00));
    base = conv_cnt;
    bus_write(4'd1, ctl_word(2'b11, 1'b1));
    bus_read(4'd1, r);
    chk(r[1] == 1'b1, "R2 busy while scanning", r[1], 1);
    wait_idle();
    chk(conv_cnt - base == 4, "R6 count once", conv_cnt - base, 4);
    for (int k = 0; k < 4; k++)
      chk(ch_log[(base + k) % 64] == 3'(k + 1), "R6 ascending order", ch_log[(base + k) % 64], k + 1);
    bus_read(4'd1, r);
    chk(r[1] == 1'b0, "R2 busy clear after scan", r[1], 0);
  endtask

  task automatic t_end_below();
    int base;
    bus_write(4'd0, sel_word(3'd2, 3'd5, 1'b0, 2'b00));
    base = conv_cnt;
    bus_write(4'd1, ctl_word(2'b11, 1'b1));
    wait_idle();
    chk(conv_cnt - base == 1, "R7 single conversion", conv_cnt - base, 1);
    chk(ch_log[base % 64] == 3'd5, "R7 start channel", ch_log[base % 64], 5);
  endtask

  task automatic t_timer();
    int base;
    bus_write(4'd0, sel_word(3'd5, 3'd4, 1'b0, 2'b01));
    base = conv_cnt;
    @(negedge clk); tmr_match = 1'b1;
    @(negedge clk); tmr_match = 1'b0;
    chk(afe_sample == 1'b1, "R3 timer start", afe_sample, 1);
    repeat (3) @(negedge clk);
    tmr_match = 1'b1;
    @(negedge clk); tmr_match = 1'b0;
    bus_write(4'd1, ctl_word(2'b11, 1'b1));
    wait_idle();
    chk(conv_cnt - base == 2, "R11 retrigger ignored", conv_cnt - base, 2);
    chk(ch_log[(base + 1) % 64] == 3'd5, "R3 second channel", ch_log[(base + 1) % 64], 5);
  endtask

  task automatic t_pin();
    int base;
    bus_write(4'd0, sel_word(3'd6, 3'd6, 1'b0, 2'b00));
    base = conv_cnt;
    @(negedge clk); ext_trig_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(!afe_sample && !afe_conv, "R5 pin ignored under software source", afe_sample, 0);
    ext_trig_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(4'd0, sel_word(3'd6, 3'd6, 1'b0, 2'b11));
    @(negedge clk); ext_trig_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!afe_sample, "R4 synchronizer delay", afe_sample, 0);
    @(negedge clk);
    chk(afe_sample == 1'b1, "R4 pin start", afe_sample, 1);
    ext_trig_n = 1'b1;
    wait_idle();
    chk(conv_cnt - base == 1, "R4 one scan", conv_cnt - base, 1);
    chk(ch_log[base % 64] == 3'd6, "R4 channel", ch_log[base % 64], 6);
  endtask

  task automatic t_reserved();
    int base;
    bus_write(4'd0, sel_word(3'd1, 3'd0, 1'b0, 2'b10));
    base = conv_cnt;
    @(negedge clk); tmr_match = 1'b1; ext_trig_n = 1'b0;
    @(negedge clk); tmr_match = 1'b0;
    bus_write(4'd1, ctl_word(2'b11, 1'b1));
    repeat (20) @(negedge clk);
    chk(conv_cnt - base == 0 && !afe_sample && !afe_conv, "R5 reserved source", conv_cnt - base, 0);
    ext_trig_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_sample();
    bus_write(4'd0, sel_word(3'd0, 3'd0, 1'b0, 2'b00));
    for (int c = 0; c < 4; c++) begin
      bus_write(4'd1, ctl_word(2'(c), 1'b1));
      wait_idle();
      chk(last_samp == 3 + 2 * c, "R9 sample window", last_samp, 3 + 2 * c);
    end
    bus_write(4'd1, ctl_word(2'b11, 1'b0));
  endtask

  task automatic t_cont();
    int base, mark;
    bus_write(4'd0, sel_word(3'd3, 3'd2, 1'b1, 2'b00));
    base = conv_cnt;
    bus_write(4'd1, ctl_word(2'b11, 1'b1));
    for (int i = 0; i < 400 && conv_cnt - base < 5; i++) @(negedge clk);
    for (int i = 0; i < 40 && !afe_sample; i++) @(negedge clk);
    mark = conv_cnt;
    bus_write(4'd1, ctl_word(2'b11, 1'b0));
    wait_idle();
    chk(conv_cnt - mark == 1, "R8 finish current channel", conv_cnt - mark, 1);
    chk(conv_cnt - base >= 6, "R8 repeated scan", conv_cnt - base, 6);
    for (int k = 0; k < 6; k++)
      chk(ch_log[(base + k) % 64] == 3'(2 + (k % 2)), "R8 wrap order", ch_log[(base + k) % 64], 2 + (k % 2));
  endtask

  task automatic t_results();
    logic [15:0] r;
    for (int c = 0; c < 8; c++) bus_read(4'(8 + c), r);
    bus_read(4'd2, r);
    chk(r == 16'h0000, "R10 flags cleared by reads", r, 0);
    bus_write(4'd0, sel_word(3'd3, 3'd1, 1'b0, 2'b00));
    bus_write(4'd1, ctl_word(2'b11, 1'b1));
    wait_idle();
    bus_read(4'd2, r);
    chk(r == 16'h000E, "R10 flags set", r, 16'h000E);
    bus_read(4'd9, r);
    chk(r == {6'b0, exp_res[1]}, "R10 result ch1", r, exp_res[1]);
    bus_read(4'd11, r);
    chk(r == {6'b0, exp_res[3]}, "R10 result ch3", r, exp_res[3]);
    bus_read(4'd2, r);
    chk(r == 16'h0004, "R10 read clears flag", r, 16'h0004);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    tmr_match = 1'b0; ext_trig_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_soft_scan();
    t_end_below();
    t_timer();
    t_pin();
    t_reserved();
    t_sample();
    t_cont();
    t_results();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule